// File: doc/BRIEF.md
# Eight-Channel Acquisition Scan Sequencer

This block sits between a simple 16-bit register port and eight sampled analog input codes. Software selects which inputs take part in a scan by writing a per-channel enable mask. A read of a dedicated start location launches a scan. For a fixed number of clock cycles a busy flag is raised in a separate 32-bit control word. When the scan finishes, every enabled channel's result register captures its current input code, sign-extended from 14 to 16 bits. Result registers of channels that are not enabled keep their previous contents.

Results are fetched through one data window that is mirrored across eight consecutive 16-bit locations. Each read of the window returns the next enabled channel's result in ascending channel order, so a driver can drain a scan with repeated reads at any mirrored address. After the highest enabled channel the sequence wraps to the lowest enabled one. A new scan resets the readout to channel 0.

Every read is answered one clock later on a registered data port, with a valid strobe.

Top module: `adc_scan_seq`

## Requirements
- R1: After a synchronous active-low reset, the busy flag is 0, the enable mask is 0, the readout pointer is 0 and every result register is 0x0000.
- R2: A write to byte offset 0x00 loads the enable mask from the low eight data bits, where bit i enables channel i. A write to any other offset changes no state.
- R3: A read of byte offset 0x20 returns 0xFFFF. When the block is idle, this read sets the busy flag and resets the readout pointer to channel 0.
- R4: The busy flag stays set for exactly CONV_CYCLES clock cycles after the start read, which is 16 by default. A start read that arrives while busy returns 0xFFFF and does not restart or extend the scan.
- R5: On the clock edge where busy clears, each channel enabled in the mask at that moment loads its 14-bit two's-complement input, sign-extended to 16 bits.
- R6: A channel that is not enabled when a scan completes keeps its previous result.
- R7: A read at any even byte offset from 0x00 to 0x0E returns the result of the lowest-numbered enabled channel at or above the pointer. The pointer then moves to one past that channel.
- R8: When no enabled channel lies at or above the pointer, a data read returns the lowest-numbered enabled channel and moves the pointer one past it.
- R9: A data read while busy is set returns 0xFFFF and leaves the pointer unchanged.
- R10: A data read while the enable mask is zero returns 0xFFFF and leaves the pointer unchanged.
- R11: Every read produces rd_valid high for exactly the following cycle, with its data on rd_data. A read of any offset outside the data window and the start location returns 0x0000. rd_data is 0x0000 whenever rd_valid is low.
- R12: ctrl_word bit 17 shows the busy flag, and every other bit of ctrl_word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset of the access |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after a read |
| rd_data | output | 16 | Read response data |
| ctrl_word | output | 32 | Control word, busy flag at bit 17 |
| sample_in | input | 112 | Eight 14-bit input codes, channel i at bits [14i+13:14i] |

## Verification
If the readout pointer holds a wrong value, the very next data read returns the wrong channel's result, or it fails to wrap. The error is visible on rd_data one cycle after that read. If the scan counter holds a wrong value, bit 17 of ctrl_word falls early or late, and data reads in the affected cycles return 0xFFFF when real data is expected, or real data when 0xFFFF is expected. A wrong latch enable shows up only when the channel is read back after the scan. For that reason, the scans are followed by reads under a wider mask, which exposes both stale and overwritten values.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the scan sequencer.
// Assumes a 16-bit register data path and byte offsets on the request address.
package adc_seq_pkg;
    localparam int unsigned REG_W      = 16;
    localparam logic [REG_W-1:0] NO_DATA = 16'hFFFF;
    localparam logic [6:0] MASK_OFF    = 7'h00;
    localparam logic [6:0] START_OFF   = 7'h20;

    // Classification of a register access by offset.
    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_START = 2'd1,
        ACC_OTHER = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/adc_conv_timer.sv
// Scan timer: raises busy for CONV_CYCLES cycles after a launch pulse.
// Assumes launch is only asserted while idle; done pulses on the final busy cycle.
module adc_conv_timer #(
    parameter int unsigned CONV_CYCLES = 16,
    localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] left_q;

    // Completion is the last cycle of the busy window.
    assign done = busy && (left_q == '0);

    // Load the cycle count on launch, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            left_q <= CNT_W'(CONV_CYCLES - 1);
        end else if (done) begin
            busy   <= 1'b0;
        end else if (busy) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result registers with sign extension of the input codes.
// Assumes capture is a single-cycle pulse; the mask selects which channels load.
module adc_result_bank #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned EXT_W   = DATA_W - SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic [NUM_CH-1:0]          enable,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    output logic [NUM_CH*DATA_W-1:0]   results
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [SAMPLE_W-1:0] code;
        assign code = samples[ch*SAMPLE_W +: SAMPLE_W];

        // Hold the result unless this channel is enabled at capture time.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                results[ch*DATA_W +: DATA_W] <= '0;
            end else if (capture && enable[ch]) begin
                results[ch*DATA_W +: DATA_W] <= {{EXT_W{code[SAMPLE_W-1]}}, code};
            end
        end
    end
endmodule

// File: rtl/adc_readout_ptr.sv
// Readout pointer: picks the next enabled channel at or above the pointer,
// wrapping to the lowest enabled channel when none remains.
// Assumes advance is only asserted when at least one channel is enabled.
module adc_readout_ptr #(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned IDX_W = $clog2(NUM_CH),
    localparam int unsigned PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [NUM_CH-1:0] enable,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              any_en,
    output logic [PTR_W-1:0]  ptr
);
    logic             above_hit;
    logic [IDX_W-1:0] above_idx;
    logic [IDX_W-1:0] low_idx;

    // Priority search from the top down so the lowest match wins.
    always_comb begin
        above_hit = 1'b0;
        above_idx = '0;
        any_en    = 1'b0;
        low_idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (enable[i]) begin
                any_en  = 1'b1;
                low_idx = IDX_W'(i);
                if (PTR_W'(i) >= ptr) begin
                    above_hit = 1'b1;
                    above_idx = IDX_W'(i);
                end
            end
        end
        sel_idx = above_hit ? above_idx : low_idx;
    end

    // Reset on a new scan, otherwise step past the channel just read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (restart) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= PTR_W'(sel_idx) + 1'b1;
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer top: decodes register accesses, owns the enable mask,
// launches scans on a start read and returns results through the data window.
// Assumes one access per request cycle; read data is registered.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned SAMPLE_W    = 14,
    parameter int unsigned CONV_CYCLES = 16,
    parameter int unsigned CTRL_W      = 32,
    parameter int unsigned BUSY_BIT    = 17,
    localparam int unsigned IDX_W      = $clog2(NUM_CH),
    localparam int unsigned PTR_W      = IDX_W + 1,
    localparam int unsigned WIN_BYTES  = NUM_CH * 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [6:0]                 req_addr,
    input  logic [REG_W-1:0]           req_wdata,
    output logic                       rd_valid,
    output logic [REG_W-1:0]           rd_data,
    output logic [CTRL_W-1:0]          ctrl_word,
    input  logic [NUM_CH*SAMPLE_W-1:0] sample_in
);
    logic [NUM_CH-1:0]       mask_q;
    logic                    busy;
    logic                    done;
    logic [NUM_CH*REG_W-1:0] res_flat;
    logic [IDX_W-1:0]        sel_idx;
    logic                    any_en;
    logic [PTR_W-1:0]        ptr;
    acc_kind_e               kind;
    logic                    rd_req;
    logic                    launch;
    logic                    advance;
    logic [REG_W-1:0]        rd_next;

    // Classify the access by its byte offset.
    always_comb begin
        if (req_addr < 7'(WIN_BYTES))   kind = ACC_DATA;
        else if (req_addr == START_OFF) kind = ACC_START;
        else                            kind = ACC_OTHER;
    end

    assign rd_req  = req_valid && !req_write;
    assign launch  = rd_req && (kind == ACC_START) && !busy;
    assign advance = rd_req && (kind == ACC_DATA) && !busy && any_en;

    // Enable mask register, written only at the mask offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (req_valid && req_write && req_addr == MASK_OFF) begin
            mask_q <= req_wdata[NUM_CH-1:0];
        end
    end

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DATA_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (done),
        .enable  (mask_q),
        .samples (sample_in),
        .results (res_flat)
    );

    adc_readout_ptr #(.NUM_CH(NUM_CH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .advance (advance),
        .enable  (mask_q),
        .sel_idx (sel_idx),
        .any_en  (any_en),
        .ptr     (ptr)
    );

    // Select the value a read returns at this offset.
    always_comb begin
        rd_next = '0;
        if (rd_req) begin
            unique case (kind)
                ACC_START: rd_next = NO_DATA;
                ACC_DATA:  rd_next = (busy || !any_en) ? NO_DATA
                                                       : res_flat[sel_idx*REG_W +: REG_W];
                default:   rd_next = '0;
            endcase
        end
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_next;
        end
    end

    // Control word carries only the busy flag.
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BUSY_BIT] = busy;
    end
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Protocol checker for the scan sequencer, bound into every instance.
// Observes the request port, the response port and internal state.
module adc_scan_seq_chk #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned CONV_CYCLES = 16,
    parameter int unsigned PTR_W       = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [6:0]              req_addr,
    input logic                    rd_valid,
    input logic [15:0]             rd_data,
    input logic                    busy,
    input logic [NUM_CH-1:0]       mask_q,
    input logic [PTR_W-1:0]        ptr,
    input logic [NUM_CH*16-1:0]    res_flat
);
    int unsigned busy_run;

    // Count consecutive busy cycles to bound the scan length.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 7'h20 && !busy) |=> busy);

    assert_start_returns_ffff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 7'h20) |=> (rd_data == 16'hFFFF));

    assert_scan_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CONV_CYCLES);

    assert_busy_read_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr < 7'(NUM_CH * 2) && busy)
        |=> (rd_data == 16'hFFFF));

    assert_busy_read_hold_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && busy) |=> $stable(ptr));

    assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (!rd_valid && rd_data == 16'h0000));

    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(NUM_CH));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_keep
        assert_disabled_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_q[ch] |=> $stable(res_flat[ch*16 +: 16]));
    end
endmodule

bind adc_scan_seq adc_scan_seq_chk #(
    .NUM_CH      (NUM_CH),
    .CONV_CYCLES (CONV_CYCLES),
    .PTR_W       (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .busy      (busy),
    .mask_q    (mask_q),
    .ptr       (ptr),
    .res_flat  (res_flat)
);

// File: tb/adc_scan_seq_test.sv
// Bench for the scan sequencer: behavioural reference model compared every
// clock, plus directed checks tagged by requirement.
module adc_scan_seq_test;
    localparam int CONV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [6:0]   req_addr = '0;
    logic [15:0]  req_wdata = '0;
    logic         rd_valid;
    logic [15:0]  rd_data;
    logic [31:0]  ctrl_word;
    logic [13:0]  samp [8];
    logic [111:0] samp_flat;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) samp_flat[i*14 +: 14] = samp[i];
    end

    adc_scan_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ctrl_word (ctrl_word),
        .sample_in (samp_flat)
    );

    // Reference model state.
    int          m_mask, m_left, m_ptr, m_pick, m_oldmask;
    bit          m_busy, m_wasbusy, m_rdv;
    logic [15:0] m_rdd;
    logic [15:0] m_res [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 0; m_left = 0; m_ptr = 0; m_busy = 0; m_rdv = 0; m_rdd = 0;
            for (int i = 0; i < 8; i++) m_res[i] = 16'h0000;
        end else begin
            m_wasbusy = m_busy;
            m_oldmask = m_mask;
            m_rdv = req_valid && !req_write;
            m_rdd = 16'h0000;
            if (m_wasbusy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0;
                    for (int i = 0; i < 8; i++)
                        if (m_oldmask[i]) m_res[i] = {{2{samp[i][13]}}, samp[i]};
                end
            end
            if (req_valid && req_write && req_addr == 7'h00) m_mask = int'(req_wdata[7:0]);
            if (m_rdv) begin
                if (req_addr == 7'h20) begin
                    m_rdd = 16'hFFFF;
                    if (!m_wasbusy) begin m_busy = 1; m_left = CONV; m_ptr = 0; end
                end else if (req_addr < 7'd16) begin
                    if (m_wasbusy || m_oldmask == 0) m_rdd = 16'hFFFF;
                    else begin
                        m_pick = -1;
                        for (int j = 0; j < 8; j++)
                            if (j >= m_ptr && m_oldmask[j] && m_pick < 0) m_pick = j;
                        for (int j = 0; j < 8; j++)
                            if (m_oldmask[j] && m_pick < 0) m_pick = j;
                        m_rdd = m_res[m_pick];
                        m_ptr = m_pick + 1;
                    end
                end
            end
        end
    end

    // Compare outputs to the model between edges.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (rd_valid !== m_rdv || rd_data !== m_rdd || ctrl_word !== {14'd0, m_busy, 17'd0}) begin
                bad++;
                $display("FAIL R11 model: got v=%b d=%h c=%h exp v=%b d=%h busy=%b",
                         rd_valid, rd_data, ctrl_word, m_rdv, m_rdd, m_busy);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Issue a read at a negedge; returns the response one cycle later.
    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] v);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic scan_and_wait();
        logic [15:0] d;
        rd(7'h20, d);
        chk("R3 start read", d, 16'hFFFF);
        while (ctrl_word[17]) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        int busy_cycles;
        samp[0] = 14'h0123; samp[1] = 14'h1FFF; samp[2] = 14'h2000; samp[3] = 14'h0AAA;
        samp[4] = 14'h3000; samp[5] = 14'h2ABC; samp[6] = 14'h0055; samp[7] = 14'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and R12 idle control word
        chk("R12 idle ctrl", ctrl_word, 32'h0);
        chk("R1 rd_valid low", {31'd0, rd_valid}, 32'h0);
        rd(7'h00, d);  chk("R10 empty mask read", d, 16'hFFFF);
        wr(7'h00, 16'h0001);
        rd(7'h00, d);  chk("R1 result reset", d, 16'h0000);

        // R2 mask write, then ignored write elsewhere
        wr(7'h00, 16'hFFA5);
        wr(7'h10, 16'h00FF);
        wr(7'h22, 16'h0000);

        // R3/R4/R9/R12: start, busy timing, reads while busy
        rd(7'h20, d);  chk("R3 start returns FFFF", d, 16'hFFFF);
        chk("R12 busy bit", ctrl_word, 32'h0002_0000);
        busy_cycles = 1;
        rd(7'h20, d);  chk("R4 start while busy", d, 16'hFFFF);
        if (ctrl_word[17]) busy_cycles++;
        rd(7'h04, d);  chk("R9 data read while busy", d, 16'hFFFF);
        if (ctrl_word[17]) busy_cycles++;
        while (ctrl_word[17]) begin
            @(negedge clk);
            if (ctrl_word[17]) busy_cycles++;
        end
        chk("R4 busy length", busy_cycles, CONV);

        // R5/R7/R8: ordered pops over mirrored offsets, sign extension, wrap
        rd(7'h00, d);  chk("R7 pop ch0", d, 16'h0123);
        rd(7'h06, d);  chk("R5 pop ch2 sign-extended", d, 16'hE000);
        rd(7'h0E, d);  chk("R2 mask kept, pop ch5", d, 16'hEABC);
        rd(7'h08, d);  chk("R7 pop ch7", d, 16'h1234);
        rd(7'h02, d);  chk("R8 wrap to ch0", d, 16'h0123);

        // R6: scan with only ch1 enabled, others keep old values
        samp[0] = 14'h0777; samp[1] = 14'h3001; samp[2] = 14'h0001;
        wr(7'h00, 16'h0002);
        scan_and_wait();
        wr(7'h00, 16'h0007);
        rd(7'h0C, d);  chk("R6 ch0 kept", d, 16'h0123);
        rd(7'h0C, d);  chk("R5 ch1 new", d, 16'hF001);
        rd(7'h0C, d);  chk("R6 ch2 kept", d, 16'hE000);
        rd(7'h0C, d);  chk("R8 wrap ch0", d, 16'h0123);

        // R3 pointer reset by a new scan (pointer currently past ch0)
        scan_and_wait();
        rd(7'h0A, d);  chk("R3 pointer reset ch0", d, 16'h0777);
        rd(7'h0A, d);  chk("R5 ch1 rescanned", d, 16'hF001);

        // R10 and R11 corner reads
        wr(7'h00, 16'h0000);
        rd(7'h00, d);  chk("R10 mask zero read", d, 16'hFFFF);
        rd(7'h30, d);  chk("R11 other offset", d, 16'h0000);
        chk("R11 valid after read", {31'd0, rd_valid}, 32'h1);
        @(negedge clk);
        chk("R11 idle data", {15'd0, rd_valid, rd_data}, 32'h0);
        chk("R12 final ctrl", ctrl_word, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule